// File: doc/BRIEF.md
# Single-Precision Divide Operand Fixup

This block is the combinational front stage of an iterative binary32 divider. It takes a numerator and a denominator word and settles every operand pair whose quotient is fixed by the operand classes alone. A NaN, infinity or zero operand needs no iteration. In those cases it returns replacement operands in which the denominator is 1.0, so the result is already carried by the numerator. It also raises the invalid or divide-by-zero flag where one applies.

For two finite nonzero operands it leaves the quotient unchanged and rescales numerator and denominator by powers of two. This keeps the reciprocal iteration that follows away from overflow and underflow. A ladder of exponent windows picks the scale factors and an 8-bit adjust code that tells the later stage how the final quotient must be corrected. The block scales by adding to the exponent field. It normalizes subnormal inputs first, so every scaled operand comes out as an exact normal number.

In the requirements, the "exponent" of an operand is its biased 8-bit field, except that a subnormal counts as exponent 1. Q is numerator exponent minus denominator exponent plus 127. Bit 31 is the sign, bits 30:23 the exponent field, bits 22:0 the fraction, and bit 22 is the quiet bit of a NaN. 1.0 is 0x3F800000.

Top module: `sp_div_prescale`

## Requirements
- R1: If either operand is a NaN, num_o, den_o and seed_o are all 0xFFFFFFFF, adj_o is 0 and iter_o is 0.
- R2: For NaN operands, inv_o is 1 when any NaN operand has bit 22 clear. With two NaNs this is the AND of their quiet bits being 0. inv_o and dbz_o are never both 1.
- R3: Infinity over infinity and zero over zero give 0xFFFFFFFF on all three words and inv_o = 1.
- R4: A finite nonzero numerator over a zero denominator gives num_o = infinity with sign = XOR of the input signs, den_o = seed_o = 1.0 and dbz_o = 1.
- R5: A finite numerator over infinity, and zero over a finite nonzero value, give num_o = zero with sign = XOR of the signs, den_o = seed_o = 1.0 and no flags.
- R6: Infinity over a finite nonzero value gives num_o = infinity with sign = XOR of the signs, den_o = seed_o = 1.0 and no flags.
- R7: For finite nonzero operands with Q <= 23, adj_o = 0x80, den_o = den_i * 2^-64 and num_o = num_i * 2^64.
- R8: Otherwise, if Q > 230, adj_o = 0x40, den_o = den_i * 2^32 and num_o = num_i * 2^-32.
- R9: Otherwise adj_o = 0 and both operands are scaled by one common factor. The factor is 2^64 if the numerator exponent is <= 25. Failing that, it is 2^32 if the denominator exponent is <= 1, then 2^-32 if the denominator exponent is > 252, else 1.
- R10: Finite nonzero operand pairs give seed_o = 0, iter_o = 1 and no flags. Every other pair gives iter_o = 0.
- R11: Subnormal inputs are scaled exactly. When iter_o = 1, both scaled words are normal numbers equal to the input value times the stated factor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| num_i | input | 32 | numerator, binary32 |
| den_i | input | 32 | denominator, binary32 |
| num_o | output | 32 | adjusted numerator |
| den_o | output | 32 | adjusted denominator |
| seed_o | output | 32 | fixed result word, or 0 when iteration follows |
| adj_o | output | 8 | adjust code: 0x80 low quotient, 0x40 high quotient, 0 none |
| iter_o | output | 1 | 1 when the divider must iterate |
| inv_o | output | 1 | invalid operation raised |
| dbz_o | output | 1 | divide by zero raised |

## Verification
The hardest situations to reach are the edges of the exponent ladder and the subnormal operands. Each window only changes its result at one exact exponent pair, and a subnormal counts as exponent 1 for the window choice while its true magnitude is far lower. The stimulus sets these pairs on purpose, one on each side of every threshold, and sends subnormals against small, large and subnormal partners. A long run of pseudo-random words, checked against a model that works in real arithmetic, then covers the mixed NaN and class combinations.

// File: rtl/fdx_pkg.sv
package fdx_pkg;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int NX_W   = EXP_W + 2;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int EXP_TOP = (1 << EXP_W) - 2;

  // exponent ladder thresholds and scale amounts
  localparam int LOW_Q     = FRAC_W;
  localparam int HIGH_Q    = EXP_TOP - 24;
  localparam int NUM_SMALL = FRAC_W + 2;
  localparam int DEN_SMALL = 1;
  localparam int DEN_BIG   = EXP_TOP - 2;
  localparam int SH_BIG    = 64;
  localparam int SH_MID    = 32;

  localparam logic [7:0] ADJ_LOWQ  = 8'h80;
  localparam logic [7:0] ADJ_HIGHQ = 8'h40;

  localparam logic [WORD_W-1:0] W_ONE = {1'b0, 1'b0, {(EXP_W-1){1'b1}}, {FRAC_W{1'b0}}};
  localparam logic [WORD_W-1:0] W_NAN = '1;

  typedef struct packed {
    logic                   nan;
    logic                   snan;
    logic                   inf;
    logic                   zero;
    logic                   sign;
    logic [EXP_W-1:0]       gexp;
    logic signed [NX_W-1:0] nexp;
    logic [FRAC_W-1:0]      nfrac;
  } opnd_t;
endpackage

// File: rtl/fdx_classify.sv
module fdx_classify
  import fdx_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output opnd_t             info_o
);
  localparam int LZ_W = $clog2(FRAC_W);

  logic [EXP_W-1:0]  ex;
  logic [FRAC_W-1:0] fr;
  logic              sub;
  logic [LZ_W-1:0]   msb;

  assign ex  = word_i[WORD_W-2 -: EXP_W];
  assign fr  = word_i[FRAC_W-1:0];
  assign sub = (ex == '0) && (fr != '0);

  always_comb begin
    msb = '0;
    for (int i = 0; i < FRAC_W; i++) begin
      if (fr[i]) msb = LZ_W'(i);
    end
  end

  always_comb begin
    info_o.nan  = (ex == '1) && (fr != '0);
    info_o.snan = info_o.nan && !fr[FRAC_W-1];
    info_o.inf  = (ex == '1) && (fr == '0);
    info_o.zero = (ex == '0) && (fr == '0);
    info_o.sign = word_i[WORD_W-1];
    info_o.gexp = sub ? EXP_W'(1) : ex;
    if (sub) begin
      info_o.nexp  = NX_W'(int'(msb) - (FRAC_W - 1));
      info_o.nfrac = fr << (FRAC_W - int'(msb));
    end else begin
      info_o.nexp  = $signed({2'b00, ex});
      info_o.nfrac = fr;
    end
  end
endmodule

// File: rtl/fdx_special.sv
module fdx_special
  import fdx_pkg::*;
(
  input  opnd_t             n_i,
  input  opnd_t             d_i,
  output logic              hit_o,
  output logic [WORD_W-1:0] num_o,
  output logic [WORD_W-1:0] den_o,
  output logic [WORD_W-1:0] seed_o,
  output logic              inv_o,
  output logic              dbz_o
);
  logic sx;
  assign sx = n_i.sign ^ d_i.sign;

  always_comb begin
    hit_o  = 1'b1;
    num_o  = W_NAN;
    den_o  = W_ONE;
    seed_o = W_ONE;
    inv_o  = 1'b0;
    dbz_o  = 1'b0;
    if (n_i.nan || d_i.nan) begin
      den_o  = W_NAN;
      seed_o = W_NAN;
      inv_o  = n_i.snan || d_i.snan;
    end else if ((n_i.inf && d_i.inf) || (n_i.zero && d_i.zero)) begin
      den_o  = W_NAN;
      seed_o = W_NAN;
      inv_o  = 1'b1;
    end else if (d_i.zero) begin
      num_o = {sx, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      dbz_o = 1'b1;
    end else if (d_i.inf || n_i.zero) begin
      num_o = {sx, {(WORD_W-1){1'b0}}};
    end else if (n_i.inf) begin
      num_o = {sx, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end else begin
      hit_o  = 1'b0;
      num_o  = '0;
      den_o  = '0;
      seed_o = '0;
    end
  end

  always_comb begin
    // R2
    flag_excl_chk: assert (!(inv_o && dbz_o))
      else $error("invalid and divide-by-zero raised together");
  end
endmodule

// File: rtl/fdx_window.sv
module fdx_window
  import fdx_pkg::*;
(
  input  logic [EXP_W-1:0]       ne_i,
  input  logic [EXP_W-1:0]       de_i,
  output logic [7:0]             adj_o,
  output logic signed [NX_W-1:0] nsh_o,
  output logic signed [NX_W-1:0] dsh_o
);
  logic signed [NX_W:0] q;
  assign q = $signed({3'b000, ne_i}) - $signed({3'b000, de_i}) + (NX_W+1)'(BIAS);

  always_comb begin
    adj_o = '0;
    nsh_o = '0;
    dsh_o = '0;
    if (q <= (NX_W+1)'(LOW_Q)) begin
      adj_o = ADJ_LOWQ;
      nsh_o = NX_W'(SH_BIG);
      dsh_o = -NX_W'(SH_BIG);
    end else if (q > (NX_W+1)'(HIGH_Q)) begin
      adj_o = ADJ_HIGHQ;
      nsh_o = -NX_W'(SH_MID);
      dsh_o = NX_W'(SH_MID);
    end else if (ne_i <= EXP_W'(NUM_SMALL)) begin
      nsh_o = NX_W'(SH_BIG);
      dsh_o = NX_W'(SH_BIG);
    end else if (de_i <= EXP_W'(DEN_SMALL)) begin
      nsh_o = NX_W'(SH_MID);
      dsh_o = NX_W'(SH_MID);
    end else if (de_i > EXP_W'(DEN_BIG)) begin
      nsh_o = -NX_W'(SH_MID);
      dsh_o = -NX_W'(SH_MID);
    end
  end
endmodule

// File: rtl/fdx_scale.sv
module fdx_scale
  import fdx_pkg::*;
(
  input  opnd_t                  op_i,
  input  logic signed [NX_W-1:0] sh_i,
  output logic [WORD_W-1:0]      word_o
);
  logic signed [NX_W-1:0] ex;
  assign ex     = op_i.nexp + sh_i;
  assign word_o = {op_i.sign, ex[EXP_W-1:0], op_i.nfrac};
endmodule

// File: rtl/sp_div_prescale.sv
module sp_div_prescale
  import fdx_pkg::*;
(
  input  logic [31:0] num_i,
  input  logic [31:0] den_i,
  output logic [31:0] num_o,
  output logic [31:0] den_o,
  output logic [31:0] seed_o,
  output logic [7:0]  adj_o,
  output logic        iter_o,
  output logic        inv_o,
  output logic        dbz_o
);
  localparam int NOPS = 2;

  logic [WORD_W-1:0]      words [NOPS];
  opnd_t                  ops   [NOPS];
  logic signed [NX_W-1:0] shs   [NOPS];
  logic [WORD_W-1:0]      scl   [NOPS];

  logic              sp_hit, sp_inv, sp_dbz;
  logic [WORD_W-1:0] sp_num, sp_den, sp_seed;
  logic [7:0]        win_adj;

  assign words[0] = num_i;
  assign words[1] = den_i;

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    fdx_classify u_cls (.word_i(words[g]), .info_o(ops[g]));
    fdx_scale    u_scl (.op_i(ops[g]), .sh_i(shs[g]), .word_o(scl[g]));
  end

  fdx_special u_sp (
    .n_i(ops[0]), .d_i(ops[1]), .hit_o(sp_hit),
    .num_o(sp_num), .den_o(sp_den), .seed_o(sp_seed),
    .inv_o(sp_inv), .dbz_o(sp_dbz)
  );

  fdx_window u_win (
    .ne_i(ops[0].gexp), .de_i(ops[1].gexp),
    .adj_o(win_adj), .nsh_o(shs[0]), .dsh_o(shs[1])
  );

  always_comb begin
    iter_o = !sp_hit;
    inv_o  = sp_inv;
    dbz_o  = sp_dbz;
    if (sp_hit) begin
      num_o  = sp_num;
      den_o  = sp_den;
      seed_o = sp_seed;
      adj_o  = '0;
    end else begin
      num_o  = scl[0];
      den_o  = scl[1];
      seed_o = '0;
      adj_o  = win_adj;
    end
  end

  always_comb begin
    // R10
    iter_clean_chk: assert (!iter_o || (seed_o == '0 && !inv_o && !dbz_o))
      else $error("iterate case carries a seed or a flag");
    // R11
    scaled_normal_chk: assert (!iter_o ||
        (num_o[30:23] != 8'h00 && num_o[30:23] != 8'hFF &&
         den_o[30:23] != 8'h00 && den_o[30:23] != 8'hFF))
      else $error("scaled operand left the normal range");
    // R7
    adj_only_iter_chk: assert (iter_o || adj_o == '0)
      else $error("adjust code on a special case");
    // R4
    dbz_shape_chk: assert (!dbz_o || (num_o[30:0] == 31'h7F800000 && den_o == W_ONE && seed_o == W_ONE))
      else $error("divide-by-zero result malformed");
  end
endmodule

// File: tb/sim_sp_div_prescale.sv
module sim_sp_div_prescale;
  localparam int PERIOD = 10;

  typedef struct {
    logic [31:0] n, d, s;
    logic [7:0]  a;
    logic        it, iv, dz;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic [31:0] num_i = '0, den_i = '0;
  logic [31:0] num_o, den_o, seed_o;
  logic [7:0]  adj_o;
  logic        iter_o, inv_o, dbz_o;

  int applied = 0, checked = 0, bad = 0;
  bit done = 0;
  exp_t sb[$];

  always #(PERIOD/2) clk = ~clk;

  sp_div_prescale u0 (
    .num_i(num_i), .den_i(den_i), .num_o(num_o), .den_o(den_o),
    .seed_o(seed_o), .adj_o(adj_o), .iter_o(iter_o),
    .inv_o(inv_o), .dbz_o(dbz_o)
  );

  function automatic real mag(logic [31:0] w);
    if (w[30:23] == 0) return real'(w[22:0]) * (2.0 ** (-149.0));
    return (1.0 + real'(w[22:0]) / 8388608.0) * (2.0 ** (real'(int'(w[30:23])) - 127.0));
  endfunction

  function automatic logic [31:0] enc(logic s, real v);
    int e = 127;
    longint f;
    while (v >= 2.0) begin v = v / 2.0; e++; end
    while (v < 1.0)  begin v = v * 2.0; e--; end
    f = longint'($rtoi((v - 1.0) * 8388608.0));
    return {s, e[7:0], f[22:0]};
  endfunction

  function automatic exp_t model(logic [31:0] n, logic [31:0] d);
    exp_t r;
    logic nn, dn, ni, di, nz, dz, sx;
    int ne, de, q, kn, kd;
    nn = n[30:23] == 8'hFF && n[22:0] != 0;  dn = d[30:23] == 8'hFF && d[22:0] != 0;
    ni = n[30:23] == 8'hFF && n[22:0] == 0;  di = d[30:23] == 8'hFF && d[22:0] == 0;
    nz = n[30:0] == 0;                       dz = d[30:0] == 0;
    sx = n[31] ^ d[31];
    r.a = 0; r.it = 0; r.iv = 0; r.dz = 0;
    r.d = 32'h3F800000; r.s = 32'h3F800000;
    if (nn || dn) begin
      r.n = '1; r.d = '1; r.s = '1;
      r.iv = (nn && !n[22]) || (dn && !d[22]);
    end else if ((ni && di) || (nz && dz)) begin
      r.n = '1; r.d = '1; r.s = '1; r.iv = 1;
    end else if (dz) begin
      r.n = {sx, 8'hFF, 23'd0}; r.dz = 1;
    end else if (di || nz) begin
      r.n = {sx, 31'd0};
    end else if (ni) begin
      r.n = {sx, 8'hFF, 23'd0};
    end else begin
      ne = (n[30:23] == 0) ? 1 : int'(n[30:23]);
      de = (d[30:23] == 0) ? 1 : int'(d[30:23]);
      q = ne - de + 127;
      kn = 0; kd = 0;
      if (q <= 23)       begin r.a = 8'h80; kn = 64;  kd = -64; end
      else if (q > 230)  begin r.a = 8'h40; kn = -32; kd = 32;  end
      else if (ne <= 25) begin kn = 64;  kd = 64;  end
      else if (de <= 1)  begin kn = 32;  kd = 32;  end
      else if (de > 252) begin kn = -32; kd = -32; end
      r.n = enc(n[31], mag(n) * (2.0 ** real'(kn)));
      r.d = enc(d[31], mag(d) * (2.0 ** real'(kd)));
      r.s = 0; r.it = 1;
    end
    return r;
  endfunction

  task automatic apply(input logic [31:0] n, input logic [31:0] d, input string tag);
    exp_t e;
    @(negedge clk);
    num_i = n; den_i = d;
    e = model(n, d);
    e.tag = tag;
    sb.push_back(e);
    applied++;
  endtask

  function automatic logic [31:0] mk(logic s, int e, logic [22:0] f);
    return {s, e[7:0], f};
  endfunction

  always @(posedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checked++;
      if (num_o !== e.n || den_o !== e.d || seed_o !== e.s || adj_o !== e.a ||
          iter_o !== e.it || inv_o !== e.iv || dbz_o !== e.dz) begin
        bad++;
        $display("FAIL %s: got n=%h d=%h s=%h a=%h it=%b iv=%b dz=%b exp n=%h d=%h s=%h a=%h it=%b iv=%b dz=%b",
                 e.tag, num_o, den_o, seed_o, adj_o, iter_o, inv_o, dbz_o,
                 e.n, e.d, e.s, e.a, e.it, e.iv, e.dz);
      end
    end
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: got hung run, exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    lf = 32'h1234ABCD;
    // R3 all-zero inputs at start: 0/0
    apply(32'h0, 32'h0, "R3 zero/zero at start");
    // R1 R2 NaN handling
    apply(32'h7FC00000, 32'h3F800000, "R1 quiet nan num");
    apply(32'h7F800001, 32'h3F800000, "R2 signaling nan num");
    apply(32'h40000000, 32'hFF800010, "R2 signaling nan den");
    apply(32'h7FC00000, 32'hFFC00001, "R2 two quiet nans");
    apply(32'h7FC00000, 32'h7F800003, "R2 quiet and signaling nans");
    apply(32'h7F800000, 32'h7FC00000, "R1 inf over nan");
    // R3
    apply(32'hFF800000, 32'h7F800000, "R3 inf over inf");
    apply(32'h80000000, 32'h00000000, "R3 zero over zero");
    // R4
    apply(32'hC0400000, 32'h00000000, "R4 neg over pos zero");
    apply(32'h00000005, 32'h80000000, "R4 subnormal over neg zero");
    // R5
    apply(32'h3F800000, 32'hFF800000, "R5 finite over neg inf");
    apply(32'h80000000, 32'h42000000, "R5 neg zero over finite");
    apply(32'h00000000, 32'h80000001, "R5 zero over neg subnormal");
    // R6
    apply(32'hFF800000, 32'hC0000000, "R6 neg inf over neg finite");
    apply(32'h7F800000, 32'h00400000, "R6 inf over subnormal");
    // R7 / R8 boundaries
    apply(mk(0, 50, 23'h1234), mk(0, 154, 23'h55), "R7 q equals 23");
    apply(mk(1, 51, 23'h1234), mk(0, 154, 23'h55), "R9 q equals 24");
    apply(mk(0, 230, 23'h7FFFFF), mk(1, 127, 0), "R9 q equals 230");
    apply(mk(0, 231, 23'h7FFFFF), mk(1, 127, 0), "R8 q equals 231");
    // R9 windows
    apply(mk(0, 25, 23'h3), mk(0, 100, 23'h9), "R9 num exp 25");
    apply(mk(0, 26, 23'h3), mk(0, 100, 23'h9), "R9 num exp 26");
    apply(mk(0, 100, 23'h7), mk(0, 1, 23'h1), "R9 den exp 1");
    apply(mk(0, 100, 23'h7), mk(0, 2, 23'h1), "R9 den exp 2");
    apply(mk(0, 240, 23'h2), mk(1, 253, 23'h4), "R9 den exp 253");
    apply(mk(0, 240, 23'h2), mk(1, 252, 23'h4), "R9 den exp 252");
    apply(mk(0, 127, 0), mk(0, 127, 0), "R10 one over one");
    // R11 subnormals
    apply(32'h00000001, 32'h3F800000, "R11 min subnormal num");
    apply(32'h807FFFFF, 32'h3F800000, "R11 max subnormal num");
    apply(mk(0, 200, 23'h1), 32'h00000001, "R11 large over min subnormal");
    apply(mk(0, 50, 23'h1), 32'h00012345, "R11 mid over subnormal");
    apply(32'h00001000, 32'h00400000, "R11 subnormal over subnormal");
    // R10 random mix
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a, b;
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      a = lf;
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      b = lf;
      if (i % 7 == 0) a[30:23] = 8'hFF;
      if (i % 11 == 0) b[30:23] = 8'h00;
      if (i % 13 == 0) b[22:0] = 0;
      apply(a, b, "R10 random operands");
    end
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule